// File: doc/BRIEF.md
# Soft-Start Current-Limit Ramp Generator

This block sets the current-limit threshold of a step-down converter while the converter starts up. When the converter is enabled, the block counts strobes from the switching oscillator. It turns that count into a small threshold code that climbs a staircase of equal steps until it reaches full scale. An external DAC and comparator use the code to raise the permitted peak current gradually, which keeps input surge current low.

When the enable is low (shutdown or standby), the pulse count is cleared and the code is forced to zero. The block also gives the threshold scaled to millivolts, for checks and observation, and a flag that shows the ramp has finished. All pins are plain control and status levels sampled on the system clock. There is no streaming interface, so there is no back-pressure.

Top module: `ss_limit_ramp`

## Requirements
- R1: When `en_i` is low, the internal pulse count is held at zero, so `limit_code_o` = 0, `limit_mv_o` = 0 and `ramp_done_o` = 0 from the first clock edge at which low enable is sampled.
- R2: The count advances by one only at a clock edge where both `en_i` and `osc_pulse_i` are high. Clock edges without a pulse leave the code and the millivolt output unchanged.
- R3: `limit_code_o` is the number of indices k in 1..STEPS for which the count is at least floor(k*FULL_COUNT/STEPS). With the defaults (512 pulses, 5 steps) the code changes at counts 102, 204, 307, 409 and 512.
- R4: `limit_mv_o` equals `limit_code_o` multiplied by MV_PER_STEP (20 mV by default), so full scale reads 100 mV.
- R5: The count saturates at FULL_COUNT and does not wrap. Further pulses keep the code at STEPS.
- R6: `ramp_done_o` is high exactly when the count has reached FULL_COUNT. It stays high until the enable is removed or reset is applied.
- R7: Dropping `en_i` in the middle of the ramp returns the code to zero on the next edge. Enabling again restarts the ramp from a count of zero.
- R8: The synchronous reset `rst` clears the count to zero, whatever the enable and pulse inputs are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Converter enable; low means shutdown or standby |
| osc_pulse_i | input | 1 | One-cycle strobe per oscillator period |
| limit_code_o | output | CODE_W (3) | Current-limit threshold step, 0..STEPS |
| ramp_done_o | output | 1 | Full-scale threshold reached |
| limit_mv_o | output | MV_W (7) | Threshold in millivolts, code times MV_PER_STEP |

## Verification
The bench builds the block with its default parameters: 512 pulses, five steps and 20 mV per step. These values are small enough that every step boundary (102, 204, 307, 409, 512) and saturation are reached many times within a few thousand cycles of dense pulsing. Directed runs cover the following:
- Continuous pulses through saturation.
- Pulses applied while disabled.
- Enable dropped mid-ramp.
- Reset asserted mid-ramp.

Seeded random enables, pulses and resets then compare every cycle against a reference count kept in the bench.

// File: rtl/ss_pkg.sv
package ss_pkg;

  // Pulse count at which step k of the staircase becomes active.
  function automatic int step_threshold(input int k, input int full, input int steps);
    return (k * full) / steps;
  endfunction

endpackage

// File: rtl/ss_pulse_counter.sv
module ss_pulse_counter #(
  parameter int FULL_COUNT = 512,
  parameter int CNT_W      = $clog2(FULL_COUNT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             pulse_i,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);

  localparam logic [CNT_W-1:0] FULL_VAL = CNT_W'(FULL_COUNT);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      count_q <= '0;
    end else if (pulse_i && (count_q != FULL_VAL)) begin
      count_q <= count_q + CNT_W'(1);
    end
  end

  assign count_o = count_q;
  assign full_o  = (count_q == FULL_VAL);

  // Disabled converter keeps the count cleared.
  assert_hold_zero_R1: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> count_q == '0);

  // Without a pulse the count does not move.
  assert_pulse_only_R2: assert property (@(posedge clk) disable iff (rst)
    (en_i && !pulse_i) |=> $stable(count_q) || !$past(en_i));

  // Saturation: a full count stays full while enabled.
  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (en_i && full_o) |=> (full_o || !$past(en_i)));

  // Reset clears the counter.
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> count_q == '0);

endmodule

// File: rtl/ss_step_decoder.sv
module ss_step_decoder
  import ss_pkg::*;
#(
  parameter int FULL_COUNT = 512,
  parameter int STEPS      = 5,
  parameter int CNT_W      = $clog2(FULL_COUNT + 1),
  parameter int CODE_W     = $clog2(STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  count_i,
  output logic [CODE_W-1:0] code_o
);

  logic [STEPS-1:0] hit;

  for (genvar k = 1; k <= STEPS; k++) begin : g_step
    localparam logic [CNT_W-1:0] THR = CNT_W'(step_threshold(k, FULL_COUNT, STEPS));
    assign hit[k-1] = (count_i >= THR);
    if (k > 1) begin : g_thermo
      // Higher steps imply all lower steps (thermometer shape).
      assert_thermo_R3: assert property (@(posedge clk) disable iff (rst)
        hit[k-1] |-> hit[k-2]);
    end
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < STEPS; i++) begin
      code_o = code_o + CODE_W'(hit[i]);
    end
  end

  assert_code_range_R3: assert property (@(posedge clk) disable iff (rst)
    code_o <= CODE_W'(STEPS));

endmodule

// File: rtl/ss_mv_scaler.sv
module ss_mv_scaler #(
  parameter int STEPS       = 5,
  parameter int MV_PER_STEP = 20,
  parameter int CODE_W      = $clog2(STEPS + 1),
  parameter int MV_W        = $clog2(STEPS * MV_PER_STEP + 1)
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [MV_W-1:0]   mv_o
);

  localparam logic [MV_W-1:0] STEP_MV = MV_W'(MV_PER_STEP);

  assign mv_o = MV_W'(code_i) * STEP_MV;

endmodule

// File: rtl/ss_limit_ramp.sv
module ss_limit_ramp #(
  parameter int FULL_COUNT  = 512,
  parameter int STEPS       = 5,
  parameter int MV_PER_STEP = 20,
  localparam int CNT_W      = $clog2(FULL_COUNT + 1),
  localparam int CODE_W     = $clog2(STEPS + 1),
  localparam int MV_W       = $clog2(STEPS * MV_PER_STEP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              osc_pulse_i,
  output logic [CODE_W-1:0] limit_code_o,
  output logic              ramp_done_o,
  output logic [MV_W-1:0]   limit_mv_o
);

  logic [CNT_W-1:0] count;
  logic             full;

  ss_pulse_counter #(
    .FULL_COUNT (FULL_COUNT),
    .CNT_W      (CNT_W)
  ) u_counter (
    .clk     (clk),
    .rst     (rst),
    .en_i    (en_i),
    .pulse_i (osc_pulse_i),
    .count_o (count),
    .full_o  (full)
  );

  ss_step_decoder #(
    .FULL_COUNT (FULL_COUNT),
    .STEPS      (STEPS),
    .CNT_W      (CNT_W),
    .CODE_W     (CODE_W)
  ) u_decoder (
    .clk     (clk),
    .rst     (rst),
    .count_i (count),
    .code_o  (limit_code_o)
  );

  ss_mv_scaler #(
    .STEPS       (STEPS),
    .MV_PER_STEP (MV_PER_STEP),
    .CODE_W      (CODE_W),
    .MV_W        (MV_W)
  ) u_scaler (
    .code_i (limit_code_o),
    .mv_o   (limit_mv_o)
  );

  assign ramp_done_o = full;

  // Done flag and top step agree (flag from counter, code from decoder).
  assert_done_top_R6: assert property (@(posedge clk) disable iff (rst)
    ramp_done_o |-> limit_code_o == CODE_W'(STEPS));

  // Full scale in millivolts when done.
  assert_full_mv_R4: assert property (@(posedge clk) disable iff (rst)
    ramp_done_o |-> limit_mv_o == MV_W'(STEPS * MV_PER_STEP));

  // Code never falls while enable stays high.
  assert_monotonic_R7: assert property (@(posedge clk) disable iff (rst)
    en_i |=> (!en_i || !$past(en_i) || limit_code_o >= $past(limit_code_o)));

  // Dropping enable zeroes the code on the next edge.
  assert_drop_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> limit_code_o == '0 && !ramp_done_o);

endmodule

// File: tb/ss_limit_ramp_tb.sv
module ss_limit_ramp_tb;

  localparam int FULL  = 512;
  localparam int STEPS = 5;
  localparam int MVS   = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_i = 1'b0;
  logic       osc_pulse_i = 1'b0;
  logic [2:0] limit_code_o;
  logic       ramp_done_o;
  logic [6:0] limit_mv_o;

  int n_cmp = 0;
  int n_bad = 0;
  int model_cnt = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ss_limit_ramp u_dut (
    .clk          (clk),
    .rst          (rst),
    .en_i         (en_i),
    .osc_pulse_i  (osc_pulse_i),
    .limit_code_o (limit_code_o),
    .ramp_done_o  (ramp_done_o),
    .limit_mv_o   (limit_mv_o)
  );

  function automatic int exp_code(input int cnt);
    int c = 0;
    for (int k = 1; k <= STEPS; k++) begin
      if (cnt >= (k * FULL) / STEPS) c = k;
    end
    return c;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d, count %0d)",
               req, act, exp, cyc, model_cnt);
    end
  endtask

  // Apply one cycle of stimulus, update the reference, check after the edge.
  task automatic step(input bit r, input bit e, input bit p);
    string rq;
    @(negedge clk);
    rst = r; en_i = e; osc_pulse_i = p;
    @(posedge clk);
    if (r || !e) model_cnt = 0;
    else if (p && model_cnt < FULL) model_cnt++;
    #1;
    if (r) rq = "R8";
    else if (!e) rq = "R1/R7";
    else if (model_cnt == FULL) rq = "R5";
    else if (!p) rq = "R2";
    else rq = "R3";
    check(rq, int'(limit_code_o), exp_code(model_cnt));
    check("R4", int'(limit_mv_o), exp_code(model_cnt) * MVS);
    check("R6", int'(ramp_done_o), (model_cnt == FULL) ? 1 : 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      summary();
    end
  end

  initial begin
    int seed = 32'h5A17;
    void'($urandom(seed));
    // Reset state (R8, R1)
    step(1, 0, 0);
    step(1, 1, 1);
    step(0, 0, 1);
    // Pulses while disabled are ignored (R1)
    for (int i = 0; i < 20; i++) step(0, 0, 1);
    // Continuous ramp through every boundary into saturation (R3, R5, R6)
    for (int i = 0; i < FULL + 40; i++) step(0, 1, 1);
    check("R5", int'(limit_code_o), STEPS);
    check("R6", int'(ramp_done_o), 1);
    // Idle cycles without pulses keep done (R2, R6)
    for (int i = 0; i < 10; i++) step(0, 1, 0);
    // Drop enable: zero next edge (R7)
    step(0, 0, 0);
    check("R7", int'(limit_code_o), 0);
    // Restart, stop mid-ramp at 300, drop enable (R7)
    for (int i = 0; i < 300; i++) step(0, 1, 1);
    check("R3", int'(limit_code_o), 2);
    step(0, 0, 1);
    check("R7", int'(limit_mv_o), 0);
    // Sparse pulses to step 1 boundary (R2, R3)
    for (int i = 0; i < 101; i++) begin step(0, 1, 1); step(0, 1, 0); end
    check("R3", int'(limit_code_o), 0);
    step(0, 1, 1);
    check("R3", int'(limit_code_o), 1);
    // Reset mid-ramp with enable high (R8)
    step(1, 1, 1);
    check("R8", int'(limit_code_o), 0);
    // Random phase
    for (int i = 0; i < 40000; i++) begin
      bit r = ($urandom % 2000) == 0;
      bit e = ($urandom % 1000) >= 3;
      bit p = ($urandom % 10) < 4;
      step(r, e, p);
    end
    summary();
  end

endmodule